// File: doc/BRIEF.md
# Link Credit Flow Controller

This block sits between a network endpoint and the router port it feeds. It runs the link-level flow control in both directions. On the send side it holds a count of free input buffers in the router. It grants a send request only when the count allows it, and it keeps the last free buffer for urgent traffic. On the receive side it tells the router when a buffer has been freed, using a small token count that it returns each cycle.

Each receive queue is set up, through a configuration mask, to return its token in one of two ways. A normal queue returns the token when software removes the message. An early-release queue returns it as soon as the message is written. An early-release queue has already given its buffer back, so it may be full when a new message arrives. Such a message, and any message whose target queue is not resident, is steered to a shared overflow queue. A 64-bit header naming the intended queue goes with it. The overflow queue always returns its tokens on removal. Queue storage and the movement of message data are handled outside the block; it sees only the queue status flags and the enqueue and dequeue events.

Top module: `lcf_credit_flow`

## Requirements
- R1: Each granted send lowers the credit count by one and each `rtr_credit_ret` pulse raises it by one. A grant and a return in the same cycle leave the count unchanged.
- R2: A send request with `tx_hi_prio` low is granted (`tx_grant` high in the same cycle) only while the credit count is 2 or more.
- R3: A send request with `tx_hi_prio` high is granted while the credit count is 1 or more. No request is granted at a count of 0.
- R4: A dequeue from a queue whose `cfg_eager` bit is 0, or a dequeue from the overflow queue (`dq_from_ovf` high), adds one token to `buf_free_tok` in the cycle after the dequeue.
- R5: An enqueue accepted into a resident queue whose `cfg_eager` bit is 1 adds one token in the cycle after the enqueue. A dequeue from such a queue adds none.
- R6: A message for a resident queue whose `cfg_eager` bit is 1 and whose `rxq_full` bit is 1 is steered to the overflow queue (`rx_to_ovf` high). `rx_ovf_hdr` carries the queue number in bits [QID_W-1:0], with bit 32 = 0 and all other bits 0. An enqueue into the overflow queue returns no token.
- R7: A message with `rx_resident` low is steered to the overflow queue whatever the state of its queue, with `rx_ovf_hdr` bit 32 = 1 and the queue number in the low bits.
- R8: When a message is steered to the overflow queue while `ovf_full` is high, `rx_accept` stays low and no token is returned for it until the overflow queue has room.
- R9: While `rst_n` is low, the credit count loads `cfg_init_credits` and `buf_free_tok` is 0. Returns at the maximum count of 2^CREDIT_W-1 hold the count at that maximum.
- R10: `buf_free_tok` is a 2-bit count. An early-release enqueue and a token-returning dequeue in the same cycle give a value of 2.
- R11: A message for a resident, full queue whose `cfg_eager` bit is 0 is neither accepted nor redirected (`rx_accept` and `rx_to_ovf` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the credit count |
| cfg_init_credits | input | CREDIT_W | Credit count loaded during reset |
| cfg_eager | input | NUM_Q | Per-queue early token release enable |
| tx_req | input | 1 | Send request |
| tx_hi_prio | input | 1 | Request is high priority |
| tx_grant | output | 1 | Send granted this cycle; consumes one credit |
| rtr_credit_ret | input | 1 | Router reports one input buffer freed |
| rx_valid | input | 1 | Arriving message waits to be enqueued |
| rx_qid | input | QID_W | Intended receive queue |
| rx_resident | input | 1 | Intended queue is resident |
| rxq_full | input | NUM_Q | Per-queue full flags |
| ovf_full | input | 1 | Overflow queue full |
| rx_accept | output | 1 | Message enqueued this cycle |
| rx_to_ovf | output | 1 | Message is routed to the overflow queue |
| rx_ovf_hdr | output | 64 | Header to prepend in the overflow queue |
| dq_valid | input | 1 | Software removed a message this cycle |
| dq_from_ovf | input | 1 | Removal was from the overflow queue |
| dq_qid | input | QID_W | Queue of the removal when not overflow |
| buf_free_tok | output | 2 | Buffer-free tokens sent to the router |

## Verification
The assertions assume that `rtr_credit_ret` never pushes the router's count beyond what the block granted plus the reset value, that `rx_qid` and `dq_qid` are below NUM_Q, and that dequeues name only queues that hold messages. The stimulus meets these conditions by construction. Returns are issued only after grants, or in the saturation test, where overshoot is the point being checked. Queue numbers come from a four-queue setup with a fixed early-release mask. The full and resident flags are driven directly, so no storage model is needed.

// File: rtl/lcf_pkg.sv
`timescale 1ns/1ps
package lcf_pkg;
    typedef enum logic [1:0] {
        ROUTE_QUEUE = 2'd0,
        ROUTE_OVF   = 2'd1,
        ROUTE_STALL = 2'd2
    } route_e;

    localparam int HDR_W       = 64;
    localparam int HDR_NR_BIT  = 32;
endpackage

// File: rtl/lcf_tx_credit.sv
`timescale 1ns/1ps
module lcf_tx_credit #(
    parameter int CREDIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CREDIT_W-1:0] init_credits,
    input  logic                req,
    input  logic                hi_prio,
    input  logic                ret,
    output logic                grant,
    output logic [CREDIT_W-1:0] credit
);
    localparam logic [CREDIT_W-1:0] MAX_CREDIT = '1;

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        grant = req && (hi_prio ? (st_q.credit != '0)
                                : (st_q.credit > CREDIT_W'(1)));
        case ({ret, grant})
            2'b10: if (st_q.credit != MAX_CREDIT) st_d.credit = st_q.credit + CREDIT_W'(1);
            2'b01: st_d.credit = st_q.credit - CREDIT_W'(1);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.credit <= init_credits;
        else        st_q <= st_d;
    end

    assign credit = st_q.credit;
endmodule

// File: rtl/lcf_rx_steer.sv
`timescale 1ns/1ps
module lcf_rx_steer #(
    parameter int NUM_Q = 4,
    localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_Q-1:0]          cfg_eager,
    input  logic                      rx_valid,
    input  logic [QID_W-1:0]          rx_qid,
    input  logic                      rx_resident,
    input  logic [NUM_Q-1:0]          rxq_full,
    input  logic                      ovf_full,
    output logic                      rx_accept,
    output logic                      rx_to_ovf,
    output logic [lcf_pkg::HDR_W-1:0] rx_ovf_hdr,
    input  logic                      dq_valid,
    input  logic                      dq_from_ovf,
    input  logic [QID_W-1:0]          dq_qid,
    output logic [1:0]                tok
);
    import lcf_pkg::*;

    typedef struct packed {
        logic [1:0] tok;
    } rx_state_t;

    rx_state_t st_d, st_q;
    route_e    route;
    logic      enq_tok, deq_tok;

    always_comb begin
        if (!rx_resident)                                 route = ROUTE_OVF;
        else if (rxq_full[rx_qid] && cfg_eager[rx_qid])   route = ROUTE_OVF;
        else if (rxq_full[rx_qid])                        route = ROUTE_STALL;
        else                                              route = ROUTE_QUEUE;

        rx_to_ovf = rx_valid && (route == ROUTE_OVF);
        rx_accept = rx_valid && ((route == ROUTE_QUEUE) ||
                                 (route == ROUTE_OVF && !ovf_full));

        rx_ovf_hdr               = '0;
        rx_ovf_hdr[QID_W-1:0]    = rx_qid;
        rx_ovf_hdr[HDR_NR_BIT]   = !rx_resident;

        enq_tok  = rx_accept && (route == ROUTE_QUEUE) && cfg_eager[rx_qid];
        deq_tok  = dq_valid && (dq_from_ovf || !cfg_eager[dq_qid]);
        st_d.tok = {1'b0, enq_tok} + {1'b0, deq_tok};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.tok <= 2'd0;
        else        st_q <= st_d;
    end

    assign tok = st_q.tok;
endmodule

// File: rtl/lcf_credit_flow.sv
`timescale 1ns/1ps
module lcf_credit_flow #(
    parameter int CREDIT_W = 4,
    parameter int NUM_Q    = 4,
    localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CREDIT_W-1:0] cfg_init_credits,
    input  logic [NUM_Q-1:0]    cfg_eager,
    input  logic                tx_req,
    input  logic                tx_hi_prio,
    output logic                tx_grant,
    input  logic                rtr_credit_ret,
    input  logic                rx_valid,
    input  logic [QID_W-1:0]    rx_qid,
    input  logic                rx_resident,
    input  logic [NUM_Q-1:0]    rxq_full,
    input  logic                ovf_full,
    output logic                rx_accept,
    output logic                rx_to_ovf,
    output logic [63:0]         rx_ovf_hdr,
    input  logic                dq_valid,
    input  logic                dq_from_ovf,
    input  logic [QID_W-1:0]    dq_qid,
    output logic [1:0]          buf_free_tok
);
    logic [CREDIT_W-1:0] credit_cnt;

    lcf_tx_credit #(.CREDIT_W(CREDIT_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_credits (cfg_init_credits),
        .req          (tx_req),
        .hi_prio      (tx_hi_prio),
        .ret          (rtr_credit_ret),
        .grant        (tx_grant),
        .credit       (credit_cnt)
    );

    lcf_rx_steer #(.NUM_Q(NUM_Q)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_eager   (cfg_eager),
        .rx_valid    (rx_valid),
        .rx_qid      (rx_qid),
        .rx_resident (rx_resident),
        .rxq_full    (rxq_full),
        .ovf_full    (ovf_full),
        .rx_accept   (rx_accept),
        .rx_to_ovf   (rx_to_ovf),
        .rx_ovf_hdr  (rx_ovf_hdr),
        .dq_valid    (dq_valid),
        .dq_from_ovf (dq_from_ovf),
        .dq_qid      (dq_qid),
        .tok         (buf_free_tok)
    );
endmodule

// File: rtl/lcf_credit_flow_chk.sv
`timescale 1ns/1ps
module lcf_credit_flow_chk #(
    parameter int CREDIT_W = 4,
    parameter int NUM_Q    = 4,
    localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_Q-1:0]    cfg_eager,
    input logic                tx_req,
    input logic                tx_hi_prio,
    input logic                tx_grant,
    input logic                rtr_credit_ret,
    input logic [CREDIT_W-1:0] credit_cnt,
    input logic                rx_valid,
    input logic [QID_W-1:0]    rx_qid,
    input logic                rx_resident,
    input logic                ovf_full,
    input logic                rx_accept,
    input logic                rx_to_ovf,
    input logic                dq_valid,
    input logic [1:0]          buf_free_tok
);
    a_r1_grant_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant && !rtr_credit_ret |=> credit_cnt == $past(credit_cnt) - CREDIT_W'(1));

    a_r2_low_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant && !tx_hi_prio |-> credit_cnt > CREDIT_W'(1));

    a_r3_high_floor: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && tx_hi_prio && credit_cnt != '0 |-> tx_grant);

    a_r3_none_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        credit_cnt == '0 |-> !tx_grant);

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (&credit_cnt) && rtr_credit_ret && !tx_grant |=> &credit_cnt);

    a_r5_eager_token: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept && !rx_to_ovf && cfg_eager[rx_qid] |=> buf_free_tok != 2'd0);

    a_r6_ovf_no_token: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept && rx_to_ovf && !dq_valid |=> buf_free_tok == 2'd0);

    a_r7_nonresident_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_resident |-> rx_to_ovf);

    a_r8_ovf_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_to_ovf && ovf_full |-> !rx_accept);

    a_r10_token_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_accept && !dq_valid |=> buf_free_tok == 2'd0);
endmodule

bind lcf_credit_flow lcf_credit_flow_chk #(.CREDIT_W(CREDIT_W), .NUM_Q(NUM_Q)) u_chk (.*);

// File: tb/tb_lcf_credit_flow.sv
`timescale 1ns/1ps
module tb_lcf_credit_flow;
    localparam int CREDIT_W = 4;
    localparam int NUM_Q    = 4;
    localparam int QID_W    = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CREDIT_W-1:0] cfg_init_credits = 4'd3;
    logic [NUM_Q-1:0]    cfg_eager = 4'b0011;
    logic                tx_req = 1'b0, tx_hi_prio = 1'b0, rtr_credit_ret = 1'b0;
    logic                tx_grant;
    logic                rx_valid = 1'b0, rx_resident = 1'b1, ovf_full = 1'b0;
    logic [QID_W-1:0]    rx_qid = '0;
    logic [NUM_Q-1:0]    rxq_full = '0;
    logic                rx_accept, rx_to_ovf;
    logic [63:0]         rx_ovf_hdr;
    logic                dq_valid = 1'b0, dq_from_ovf = 1'b0;
    logic [QID_W-1:0]    dq_qid = '0;
    logic [1:0]          buf_free_tok;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lcf_credit_flow #(.CREDIT_W(CREDIT_W), .NUM_Q(NUM_Q)) dut (.*);

    // {ret, req, hi, expected grant}; starts from 3 credits
    localparam logic [3:0] TXV [10] = '{
        4'b0101, 4'b0101, 4'b0100, 4'b0111, 4'b0110,
        4'b1000, 4'b1111, 4'b1100, 4'b0101, 4'b0100
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [CREDIT_W-1:0] init);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_init_credits = init;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rx_step(input logic v, input logic [1:0] q, input logic res,
                           input logic [3:0] full, input logic ofull,
                           input logic dv, input logic dovf, input logic [1:0] dq,
                           input string tag, input logic exp_acc, input logic exp_ovf,
                           input logic [63:0] exp_hdr, input logic [1:0] exp_tok);
        @(negedge clk);
        rx_valid = v; rx_qid = q; rx_resident = res; rxq_full = full; ovf_full = ofull;
        dq_valid = dv; dq_from_ovf = dovf; dq_qid = dq;
        #1;
        check({tag, " accept"}, 64'(rx_accept), 64'(exp_acc));
        check({tag, " to_ovf"}, 64'(rx_to_ovf), 64'(exp_ovf));
        if (exp_ovf) check({tag, " hdr"}, rx_ovf_hdr, exp_hdr);
        @(negedge clk);
        rx_valid = 1'b0; dq_valid = 1'b0; rxq_full = '0; ovf_full = 1'b0; rx_resident = 1'b1;
        #1;
        check({tag, " tok"}, 64'(buf_free_tok), 64'(exp_tok));
    endtask

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        do_reset(4'd3);
        #1;
        check("R9 reset tok", 64'(buf_free_tok), 64'd0);
        check("R9 reset idle grant", 64'(tx_grant), 64'd0);

        // R1 R2 R3 table walk
        foreach (TXV[i]) begin
            @(negedge clk);
            rtr_credit_ret = TXV[i][3];
            tx_req         = TXV[i][2];
            tx_hi_prio     = TXV[i][1];
            #1;
            check($sformatf("R1/R2/R3 tx vector %0d", i), 64'(tx_grant), 64'(TXV[i][0]));
        end
        @(negedge clk);
        tx_req = 1'b0; rtr_credit_ret = 1'b0;

        // R9 saturation: start at max, extra returns do not raise it
        do_reset(4'd15);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rtr_credit_ret = 1'b1;
        end
        @(negedge clk);
        rtr_credit_ret = 1'b0;
        begin
            int grants = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                tx_req = 1'b1; tx_hi_prio = 1'b0;
                #1;
                if (tx_grant) grants++;
            end
            @(negedge clk);
            tx_req = 1'b0;
            check("R9 saturation low grants", 64'(grants), 64'd14);
        end

        // R9 R3 load of zero: high priority refused
        do_reset(4'd0);
        @(negedge clk);
        tx_req = 1'b1; tx_hi_prio = 1'b1;
        #1;
        check("R3 zero credit high req", 64'(tx_grant), 64'd0);
        @(negedge clk);
        tx_req = 1'b0;

        // receive side, eager mask 0011
        rx_step(1, 2'd0, 1, 4'b0000, 0, 0, 0, 2'd0, "R5 eager enq q0", 1, 0, 64'd0, 2'd1);
        rx_step(1, 2'd2, 1, 4'b0000, 0, 0, 0, 2'd0, "R4 normal enq q2", 1, 0, 64'd0, 2'd0);
        rx_step(0, 2'd0, 1, 4'b0000, 0, 1, 0, 2'd2, "R4 normal deq q2", 0, 0, 64'd0, 2'd1);
        rx_step(0, 2'd0, 1, 4'b0000, 0, 1, 0, 2'd0, "R5 eager deq q0", 0, 0, 64'd0, 2'd0);
        rx_step(1, 2'd1, 1, 4'b0010, 0, 0, 0, 2'd0, "R6 full eager q1", 1, 1, 64'h1, 2'd0);
        rx_step(1, 2'd3, 0, 4'b0000, 0, 0, 0, 2'd0, "R7 nonresident q3", 1, 1,
                64'h0000_0001_0000_0003, 2'd0);
        rx_step(0, 2'd0, 1, 4'b0000, 0, 1, 1, 2'd1, "R4 ovf deq", 0, 0, 64'd0, 2'd1);
        rx_step(1, 2'd1, 1, 4'b0010, 1, 0, 0, 2'd0, "R8 ovf full stall", 0, 1, 64'h1, 2'd0);
        rx_step(1, 2'd2, 1, 4'b0100, 0, 0, 0, 2'd0, "R11 normal full stall", 0, 0, 64'd0, 2'd0);
        rx_step(1, 2'd1, 1, 4'b0000, 0, 1, 0, 2'd3, "R10 double token", 1, 0, 64'd0, 2'd2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule